// File: doc/BRIEF.md
# SMBus Telemetry Register Slave

This block is a slave on a two-wire management bus (SMBus/I2C timing, no clock stretching). A host reads sensor and identity words from it and writes one control register. The block runs on a fast system clock. It oversamples SCL and SDA through a synchronizer and a majority filter, then finds START and STOP conditions and SCL edges. A byte-level state machine moves through the address, pointer, data and acknowledge phases. SDA is open-drain: the block only ever pulls the line low.

A read is a combined transfer. The host writes a one-byte register pointer and issues a repeated START with the read address. It then clocks out four bytes, least significant byte first, and NACKs the last one. The block captures the whole 32-bit word when it acknowledges the read address, so every byte of the burst comes from the same sample. Register contents come from parallel input words, which are sampled as they are: no float conversion is done. A write to the throttle register sets or clears a frequency-throttle request output.

Top module: `mgmt_regslave`

## Requirements
- R1: The block ACKs the address byte 0x8E (7-bit address 0x47, write) and 0x8F (read). Any other address byte gets no ACK, and the block leaves SDA alone until the next START.
- R2: After a pointer write and a repeated START with 0x8F, the block sends four bytes: bits [7:0] first, then [15:8], [23:16] and [31:24]. Each byte is sent most significant bit first.
- R3: Pointer 0x01 returns `pwr_word_i`, 0x02 returns `brd_temp_i`, 0x03 returns `die_temp_i`, 0xA0 returns `id_word_i` (vendor code in [15:0], device code in [31:16]) and 0xA1 returns `subid_word_i`.
- R4: A read of any other pointer returns 0x00000000. This includes the write-only pointer 0x05.
- R5: The 32-bit word is captured when the read address is acknowledged. Input changes after that point do not reach any byte of the burst.
- R6: If the host ACKs the fourth byte, the block stops driving SDA, so any further byte reads as 0xFF. After a host NACK the block does not drive SDA again until a new START.
- R7: The block ACKs each data byte written after pointer 0x05. Data 0x04 sets `throttle_o` to 1 and data 0x01 clears it to 0.
- R8: Any other data byte written to 0x05 leaves `throttle_o` unchanged. So does any data byte written to another pointer.
- R9: A STOP or START at any bit position ends the current transfer. A partial pointer byte is discarded, and the next full transfer works normally.
- R10: `sda_oe` = 1 means pull SDA low. It changes only while SCL is low, so the block never creates a START or STOP of its own.
- R11: A pulse of a single system clock on SCL or SDA is filtered out. It neither counts as a clock edge nor as a START or STOP.
- R12: During and after reset, `sda_oe` is 0 and `throttle_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| pwr_word_i | input | 32 | Card power word (pointer 0x01) |
| brd_temp_i | input | 32 | Board temperature word (pointer 0x02) |
| die_temp_i | input | 32 | Die temperature word (pointer 0x03) |
| id_word_i | input | 32 | Vendor/device identity word (pointer 0xA0) |
| subid_word_i | input | 32 | Sub-vendor/sub-system word (pointer 0xA1) |
| throttle_o | output | 1 | Frequency-throttle request |

## Verification
The hardest cases to reach are the aborts and glitches that fall inside a byte. A bus master driven from ports would not normally produce them. The bench master is built from bit-level tasks, so it can stop partway through a pointer byte and issue a STOP or a repeated START there. It can also send an address byte with a one-cycle pulse on SCL in the low phase and a one-cycle dip on SDA in the high phase. A bench monitor checks on every cycle that `sda_oe` never changes while the master holds SCL high.

// File: rtl/mgmt_regslave_pkg.sv
package mgmt_regslave_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } slv_state_e;

  localparam logic [7:0] PTR_POWER   = 8'h01;
  localparam logic [7:0] PTR_BRDTEMP = 8'h02;
  localparam logic [7:0] PTR_DIETEMP = 8'h03;
  localparam logic [7:0] PTR_BRAKE   = 8'h05;
  localparam logic [7:0] PTR_IDENT   = 8'hA0;
  localparam logic [7:0] PTR_SUBID   = 8'hA1;

  localparam logic [7:0] BRAKE_ON  = 8'h04;
  localparam logic [7:0] BRAKE_OFF = 8'h01;

endpackage

// File: rtl/mrs_line_filter.sv
module mrs_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_TAPS-1:0]   win_q;
  logic                   filt_q;
  logic                   filt_d;

  always_comb begin
    int ones;
    ones = 0;
    for (int i = 0; i < FILT_TAPS; i++) begin
      ones = ones + int'(win_q[i]);
    end
    filt_d = (ones > (FILT_TAPS / 2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      win_q  <= {win_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      filt_q <= filt_d;
    end
  end

  assign line_o = filt_q;

  // R11
  filt_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> (filt_q == $past(win_q[0])));

endmodule

// File: rtl/mrs_bus_events.sv
module mrs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_d_q;
  logic sda_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_f;
      sda_d_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_d_q;
  assign scl_fall  = ~scl_f & scl_d_q;
  assign start_det = scl_f & scl_d_q & sda_d_q & ~sda_f;
  assign stop_det  = scl_f & scl_d_q & ~sda_d_q & sda_f;

endmodule

// File: rtl/mrs_reg_bank.sv
module mrs_reg_bank
  import mgmt_regslave_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ptr_i,
  input  logic [REG_W-1:0] pwr_word_i,
  input  logic [REG_W-1:0] brd_temp_i,
  input  logic [REG_W-1:0] die_temp_i,
  input  logic [REG_W-1:0] id_word_i,
  input  logic [REG_W-1:0] subid_word_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  output logic [REG_W-1:0] rd_word_o,
  output logic             throttle_o
);

  logic throttle_q;
  logic throttle_d;

  always_comb begin
    case (ptr_i)
      PTR_POWER:   rd_word_o = pwr_word_i;
      PTR_BRDTEMP: rd_word_o = brd_temp_i;
      PTR_DIETEMP: rd_word_o = die_temp_i;
      PTR_IDENT:   rd_word_o = id_word_i;
      PTR_SUBID:   rd_word_o = subid_word_i;
      default:     rd_word_o = '0;
    endcase
  end

  always_comb begin
    throttle_d = throttle_q;
    if (wr_en_i && (ptr_i == PTR_BRAKE)) begin
      if (wr_data_i == BRAKE_ON) begin
        throttle_d = 1'b1;
      end else if (wr_data_i == BRAKE_OFF) begin
        throttle_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      throttle_q <= 1'b0;
    end else begin
      throttle_q <= throttle_d;
    end
  end

  assign throttle_o = throttle_q;

  // R8
  throttle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(throttle_q) |-> ($past(wr_en_i) && ($past(ptr_i) == PTR_BRAKE) &&
      (($past(wr_data_i) == BRAKE_ON) || ($past(wr_data_i) == BRAKE_OFF))));

endmodule

// File: rtl/mgmt_regslave.sv
module mgmt_regslave
  import mgmt_regslave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h47,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_TAPS   = 3,
  parameter int         REG_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [REG_W-1:0] pwr_word_i,
  input  logic [REG_W-1:0] brd_temp_i,
  input  logic [REG_W-1:0] die_temp_i,
  input  logic [REG_W-1:0] id_word_i,
  input  logic [REG_W-1:0] subid_word_i,
  output logic             throttle_o
);

  localparam int BYTES = REG_W / 8;
  localparam int IDX_W = $clog2(BYTES) + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  // line conditioning
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;

  mrs_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) u_scl_filt (
    .clk(clk), .rst_n(rst_core_n), .line_i(scl_i), .line_o(scl_f)
  );

  mrs_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_TAPS(FILT_TAPS)) u_sda_filt (
    .clk(clk), .rst_n(rst_core_n), .line_i(sda_i), .line_o(sda_f)
  );

  mrs_bus_events u_events (
    .clk(clk), .rst_n(rst_core_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // byte engine state
  slv_state_e       state_q, state_d;
  logic [2:0]       bitcnt_q, bitcnt_d;
  logic             done_q, done_d;
  logic [7:0]       rx_q, rx_d;
  logic [7:0]       ptr_q, ptr_d;
  logic             rw_q, rw_d;
  logic             nack_q, nack_d;
  logic [REG_W-1:0] snap_q, snap_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             oe_q, oe_d;
  logic             wr_en;
  logic [REG_W-1:0] rd_word;
  logic [IDX_W-1:0] idx_next;

  mrs_reg_bank #(.REG_W(REG_W)) u_bank (
    .clk(clk), .rst_n(rst_core_n), .ptr_i(ptr_q),
    .pwr_word_i(pwr_word_i), .brd_temp_i(brd_temp_i), .die_temp_i(die_temp_i),
    .id_word_i(id_word_i), .subid_word_i(subid_word_i),
    .wr_en_i(wr_en), .wr_data_i(rx_q),
    .rd_word_o(rd_word), .throttle_o(throttle_o)
  );

  // 1 when the given bit of the given byte of the snapshot is a zero to drive
  function automatic logic tx_low(input logic [REG_W-1:0] w,
                                  input logic [IDX_W-1:0] idx,
                                  input logic [2:0]       bitn);
    logic [7:0] b;
    b = '0;
    if (idx >= IDX_W'(BYTES)) begin
      return 1'b0;
    end
    b = w[int'(idx)*8 +: 8];
    return ~b[3'd7 - bitn];
  endfunction

  assign idx_next = (idx_q >= IDX_W'(BYTES)) ? idx_q : (idx_q + IDX_W'(1));

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    done_d   = done_q;
    rx_d     = rx_q;
    ptr_d    = ptr_q;
    rw_d     = rw_q;
    nack_d   = nack_q;
    snap_d   = snap_q;
    idx_d    = idx_q;
    oe_d     = oe_q;
    wr_en    = 1'b0;

    if (start_det) begin
      state_d  = ST_ADDR;
      bitcnt_d = '0;
      done_d   = 1'b0;
      oe_d     = 1'b0;
    end else if (stop_det) begin
      state_d  = ST_IDLE;
      bitcnt_d = '0;
      done_d   = 1'b0;
      oe_d     = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise && !done_q) begin
            rx_d = {rx_q[6:0], sda_f};
            if (bitcnt_q == 3'd7) begin
              done_d = 1'b1;
            end else begin
              bitcnt_d = bitcnt_q + 3'd1;
            end
          end else if (scl_fall && done_q) begin
            done_d   = 1'b0;
            bitcnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (rx_q[7:1] == DEV_ADDR) begin
                state_d = ST_ADDR_ACK;
                oe_d    = 1'b1;
                rw_d    = rx_q[0];
                if (rx_q[0]) begin
                  snap_d = rd_word;
                end
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_PTR) begin
              ptr_d   = rx_q;
              state_d = ST_PTR_ACK;
              oe_d    = 1'b1;
            end else begin
              wr_en   = 1'b1;
              state_d = ST_WDATA_ACK;
              oe_d    = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              state_d  = ST_RDATA;
              idx_d    = '0;
              bitcnt_d = '0;
              oe_d     = tx_low(snap_q, '0, 3'd0);
            end else begin
              state_d = ST_PTR;
              oe_d    = 1'b0;
            end
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            state_d = ST_WDATA;
            oe_d    = 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bitcnt_q == 3'd7) begin
              state_d  = ST_RACK;
              bitcnt_d = '0;
              oe_d     = 1'b0;
            end else begin
              bitcnt_d = bitcnt_q + 3'd1;
              oe_d     = tx_low(snap_q, idx_q, bitcnt_q + 3'd1);
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_d = sda_f;
          end else if (scl_fall) begin
            if (nack_q) begin
              state_d = ST_IDLE;
            end else begin
              idx_d   = idx_next;
              state_d = ST_RDATA;
              oe_d    = tx_low(snap_q, idx_next, 3'd0);
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      done_q   <= 1'b0;
      rx_q     <= '0;
      ptr_q    <= '0;
      rw_q     <= 1'b0;
      nack_q   <= 1'b0;
      snap_q   <= '0;
      idx_q    <= '0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      done_q   <= done_d;
      rx_q     <= rx_d;
      ptr_q    <= ptr_d;
      rw_q     <= rw_d;
      nack_q   <= nack_d;
      snap_q   <= snap_d;
      idx_q    <= idx_d;
      oe_q     <= oe_d;
    end
  end

  assign sda_oe = oe_q;

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$stable(oe_q) |-> !scl_f);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    stop_det |=> ((state_q == ST_IDLE) && !oe_q));

  // R1
  addr_nack_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((state_q == ST_ADDR) && scl_fall && done_q && (rx_q[7:1] != DEV_ADDR) &&
     !start_det && !stop_det) |=> (!oe_q && (state_q == ST_IDLE)));

  // R5
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (((state_q == ST_RDATA) || (state_q == ST_RACK)) &&
     (($past(state_q) == ST_RDATA) || ($past(state_q) == ST_RACK))) |-> $stable(snap_q));

endmodule

// File: tb/mgmt_regslave_tb.sv
module mgmt_regslave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk;
  logic        rst_n;
  logic        scl_m;
  logic        sda_m;
  logic        sda_line;
  logic        sda_oe;
  logic        throttle_o;
  logic [31:0] pwr_w, brd_w, die_w, id_w, sub_w;

  int n_checks;
  int n_fail;
  int oe_hi_changes;
  logic prev_oe;
  bit finished;

  assign sda_line = sda_m & ~sda_oe;

  mgmt_regslave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .pwr_word_i(pwr_w), .brd_temp_i(brd_w), .die_temp_i(die_w),
    .id_word_i(id_w), .subid_word_i(sub_w), .throttle_o(throttle_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // R10 monitor: the slave may only move its drive while SCL is low
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl_m) oe_hi_changes++;
    prev_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q/2);
    b = sda_line; tick(Q - Q/2);
    scl_m = 1'b0; tick(Q);
  endtask

  // one-cycle pulse on SCL during the low phase and/or on SDA during the high phase
  task automatic send_bit_glitch(input logic b, input bit scl_gl, input bit sda_gl);
    sda_m = b;      tick(3);
    scl_m = scl_gl; tick(1);
    scl_m = 1'b0;   tick(Q-4);
    scl_m = 1'b1;   tick(3);
    sda_m = sda_gl ? ~b : b; tick(1);
    sda_m = b;      tick(Q-4);
    scl_m = 1'b0;   tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack_n);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(ack_n);
  endtask

  task automatic read_byte(input bit last, output logic [7:0] d);
    logic b;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      recv_bit(b);
      d = {d[6:0], b};
    end
    send_bit(last ? 1'b1 : 1'b0);
  endtask

  // pointer write, repeated start, n bytes read; returns bytes low first
  task automatic read_raw(input logic [7:0] ptr, input int nbytes,
                          output logic [39:0] data, output logic [2:0] acks);
    logic a;
    logic [7:0] d;
    data = '0;
    bus_start();
    write_byte(8'h8E, a); acks[0] = a;
    write_byte(ptr, a);   acks[1] = a;
    bus_start();
    write_byte(8'h8F, a); acks[2] = a;
    for (int i = 0; i < nbytes; i++) begin
      read_byte(i == nbytes-1, d);
      data[i*8 +: 8] = d;
    end
    bus_stop();
  endtask

  task automatic write_reg(input logic [7:0] ptr, input logic [7:0] val, output logic [2:0] acks);
    logic a;
    bus_start();
    write_byte(8'h8E, a); acks[0] = a;
    write_byte(ptr, a);   acks[1] = a;
    write_byte(val, a);   acks[2] = a;
    bus_stop();
  endtask

  task automatic t_reset();
    check("R12 sda_oe in reset", 64'(sda_oe), 64'd0);
    check("R12 throttle_o in reset", 64'(throttle_o), 64'd0);
  endtask

  task automatic t_addr_nack();
    logic a;
    bus_start();
    write_byte(8'hA0, a);
    check("R1 foreign address not acked", 64'(a), 64'd1);
    bus_stop();
  endtask

  task automatic t_map();
    logic [39:0] d;
    logic [2:0]  ak;
    read_raw(8'h01, 4, d, ak);
    check("R1 acks on 8E/ptr/8F", 64'(ak), 64'd0);
    check("R2 R3 ptr 01 power word low byte first", 64'(d[31:0]), 64'(pwr_w));
    read_raw(8'h02, 4, d, ak);
    check("R3 ptr 02", 64'(d[31:0]), 64'(brd_w));
    read_raw(8'h03, 4, d, ak);
    check("R3 ptr 03", 64'(d[31:0]), 64'(die_w));
    read_raw(8'hA0, 4, d, ak);
    check("R3 ptr A0 identity", 64'(d[31:0]), 64'(id_w));
    read_raw(8'hA1, 4, d, ak);
    check("R3 ptr A1 sub identity", 64'(d[31:0]), 64'(sub_w));
    read_raw(8'h07, 4, d, ak);
    check("R4 unmapped ptr reads zero", 64'(d[31:0]), 64'd0);
    read_raw(8'h05, 4, d, ak);
    check("R4 write-only ptr reads zero", 64'(d[31:0]), 64'd0);
  endtask

  task automatic t_snapshot();
    logic a;
    logic [7:0] d;
    logic [31:0] got;
    logic [31:0] old;
    old = pwr_w;
    bus_start();
    write_byte(8'h8E, a);
    write_byte(8'h01, a);
    bus_start();
    write_byte(8'h8F, a);
    pwr_w = 32'h0BAD_F00D;
    for (int i = 0; i < 4; i++) begin
      read_byte(i == 3, d);
      got[i*8 +: 8] = d;
    end
    bus_stop();
    check("R5 snapshot taken at read-address ack", 64'(got), 64'(old));
  endtask

  task automatic t_overrun();
    logic [39:0] d;
    logic [2:0]  ak;
    read_raw(8'h03, 5, d, ak);
    check("R6 four bytes before overrun", 64'(d[31:0]), 64'(die_w));
    check("R6 fifth byte released", 64'(d[39:32]), 64'hFF);
  endtask

  task automatic t_throttle();
    logic [2:0] ak;
    write_reg(8'h05, 8'h04, ak);
    check("R7 all write bytes acked", 64'(ak), 64'd0);
    check("R7 code 04 sets throttle", 64'(throttle_o), 64'd1);
    write_reg(8'h05, 8'h33, ak);
    check("R8 other code ignored", 64'(throttle_o), 64'd1);
    write_reg(8'h02, 8'h01, ak);
    check("R8 restore code on other ptr ignored", 64'(throttle_o), 64'd1);
    write_reg(8'h05, 8'h01, ak);
    check("R7 code 01 clears throttle", 64'(throttle_o), 64'd0);
    write_reg(8'h03, 8'h04, ak);
    check("R8 brake code on other ptr ignored", 64'(throttle_o), 64'd0);
  endtask

  task automatic t_abort();
    logic a;
    logic [7:0] d;
    logic [31:0] got;
    logic [39:0] rd;
    logic [2:0] ak;
    read_raw(8'h02, 4, rd, ak);
    // STOP inside the pointer byte
    bus_start();
    write_byte(8'h8E, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    // START inside the pointer byte, then a read: partial pointer discarded
    bus_start();
    write_byte(8'h8E, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    write_byte(8'h8F, a);
    check("R9 address acked after mid-byte START", 64'(a), 64'd0);
    for (int i = 0; i < 4; i++) begin
      read_byte(i == 3, d);
      got[i*8 +: 8] = d;
    end
    bus_stop();
    check("R9 pointer kept after aborted byte", 64'(got), 64'(brd_w));
  endtask

  task automatic t_glitch();
    logic a;
    logic [7:0] adr;
    adr = 8'h8E;
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit_glitch(adr[i], i == 7, i == 3);
    recv_bit(a);
    check("R11 glitches filtered, address acked", 64'(a), 64'd0);
    bus_stop();
  endtask

  initial begin
    n_checks = 0; n_fail = 0; oe_hi_changes = 0; finished = 0;
    prev_oe = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1;
    pwr_w = 32'h42C8_3A17;
    brd_w = 32'h4234_91E5;
    die_w = 32'h4259_C6D2;
    id_w  = 32'h0270_CABC;
    sub_w = 32'h0018_CABC;
    rst_n = 1'b0;
    tick(5);
    t_reset();
    rst_n = 1'b1;
    tick(10);
    t_addr_nack();
    t_map();
    t_snapshot();
    pwr_w = 32'h42C8_3A17;
    t_overrun();
    t_throttle();
    t_abort();
    t_glitch();
    check("R10 no drive change while SCL high", 64'(oe_hi_changes), 64'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule